// File: doc/BRIEF.md
# Byte-Lane Strobe and Output Control for a x16 Extended-Data-Out DRAM

This block is the control logic that sits behind the pins of a sixteen-bit extended-data-out DRAM. It samples the active-low row strobe, the two active-low byte-lane column strobes, the write enable and the output enable on a system clock. From them it derives one internal column strobe, a capture enable and an output-drive enable for each byte lane, and a classification of the current cycle. That classification is one of read, early write, late write, or refresh selected by column-before-row strobe ordering.

The internal column strobe is active while either lane strobe is low. It latches the column address and decides whether a row-strobe fall starts a refresh. Capturing write data and driving read data stay separate per lane. Read data keeps being driven after the lane strobe rises, so long as the row strobe and the output enable stay low and no write-enable fall has intervened. A refresh takes its row from an internal wrapping counter instead of the address pins. A small internal array holds the stored words, so the whole behaviour can be seen at the ports.

Top module: `edo_lane_ctrl`

## Requirements
- R1: `casInt` is 1 whenever `caslN` or `cashN` is low, and is 0 only when both are high.
- R2: The column address is latched on the edge where the first lane strobe falls. A lane that falls later in the same internal strobe cycle uses that column and ignores the address pins.
- R3: A lane strobe falling with `weN` low is an early write. It stores that lane's byte of `dqIn` (lower lane = bits 7:0 via `caslN`, upper lane = bits 15:8 via `cashN`) at the latched row and column. The other lane's byte is left unchanged, and `laneWrite` pulses for that lane on the following cycle.
- R4: A `weN` fall while a lane strobe is already low in a read, with `oeN` high, is a late write. It stores that lane's byte of `dqIn` at the latched address.
- R5: A late write tried with `oeN` low stores nothing, and the lane keeps driving the data it read.
- R6: Read data stays driven (`dqOe` bit 1) after the lane strobe rises, while `rasN` and `oeN` stay low. `dqOe` is 0 whenever `rasN` is high.
- R7: `oeN` high forces `dqOe` to 0 at once. Taking `oeN` low again drives the same data again.
- R8: A `weN` fall during a page turns a lane's output off. The lane stays off, whatever `oeN` does, until that lane's strobe falls with `weN` high.
- R9: A `rasN` fall while `casInt` was already active starts a refresh. `refreshRow` takes the value of a 12-bit counter, and the counter then steps by one, wrapping from 4095 to 0. Lane strobe activity during a refresh stores nothing.
- R10: `cycleKind` reports 0 idle, 1 read, 2 early write, 3 late write or 4 refresh on the cycle after the edge that starts that access. It returns to 0 on the cycle after `rasN` rises.
- R11: `modeErr` is a one-cycle pulse raised when one lane writes in a write mode (early versus late) that differs from the other lane's write in the same internal strobe cycle.
- R12: After reset `dqOe`, `cycleKind`, `refreshRow`, `laneWrite` and `modeErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Active-low row strobe |
| caslN | input | 1 | Active-low strobe of the lower byte lane |
| cashN | input | 1 | Active-low strobe of the upper byte lane |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| addr | input | ADDR_W (12) | Multiplexed row/column address |
| dqIn | input | 16 | Write data, both lanes |
| dqOut | output | 16 | Read data, both lanes |
| dqOe | output | 2 | Per-lane output drive (bit 0 lower, bit 1 upper) |
| casInt | output | 1 | Internal column strobe, active high |
| laneWrite | output | 2 | Per-lane pulse: a byte was stored on the last edge |
| cycleKind | output | 3 | Current cycle class, encoded as in R10 |
| refreshRow | output | REF_W (12) | Row taken by the latest refresh |
| modeErr | output | 1 | Mixed write-mode pulse |

## Verification
On every clock, the assertions check the relations that hold at any moment. These are the first-low/last-high shape of the internal strobe, silence of the outputs when the output enable or row strobe is high, the one-step advance of the refresh row, the single-cycle error pulse, and that stores happen only in write-classed cycles. Only the scenarios can show what depends on order. That covers which column a late-falling lane uses, whether a blocked late write really left the array alone, and that high impedance persists after a write-enable fall until the next read strobe. It also covers hold of data past the strobe rise, and the counter wrap after 4096 refreshes.

// File: rtl/dram_lane_pkg.sv
package dram_lane_pkg;
  localparam int LANES = 2;

  typedef enum logic [2:0] {
    CK_IDLE    = 3'd0,
    CK_READ    = 3'd1,
    CK_EARLY   = 3'd2,
    CK_LATE    = 3'd3,
    CK_REFRESH = 3'd4
  } kind_t;

  typedef enum logic [1:0] {
    LM_NONE  = 2'd0,
    LM_READ  = 2'd1,
    LM_EARLY = 2'd2,
    LM_LATE  = 2'd3
  } lmode_t;

  typedef struct packed {
    logic             rowLoad;
    logic             colLoad;
    logic [LANES-1:0] wrEn;
    logic [LANES-1:0] rdLoad;
  } strobe_t;
endpackage

// File: rtl/edo_lane_seq.sv
module edo_lane_seq
  import dram_lane_pkg::*;
#(
  parameter int REF_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rasN,
  input  logic             caslN,
  input  logic             cashN,
  input  logic             weN,
  input  logic             oeN,
  output strobe_t          strobe,
  output logic [LANES-1:0] dqOe,
  output logic             casInt,
  output logic [LANES-1:0] laneWrite,
  output kind_t            cycleKind,
  output logic [REF_W-1:0] refreshRow,
  output logic             modeErr
);
  logic             rasQ, weQ, cbrQ;
  logic [LANES-1:0] laneQ, laneN, validQ;
  lmode_t           modeQ [LANES];
  logic [REF_W-1:0] refCnt;

  logic casNowN, casPrevN, rasFall, rasRise, casRise, casFall, weFall, inPage, refreshHit;
  logic errNow;
  logic [LANES-1:0] laneFall, earlyW, rdL, lateTry, lateW;

  assign laneN      = {cashN, caslN};
  assign casNowN    = &laneN;
  assign casPrevN   = &laneQ;
  assign rasFall    = rasQ & ~rasN;
  assign rasRise    = ~rasQ & rasN;
  assign casRise    = ~casPrevN & casNowN;
  assign inPage     = ~rasN & ~rasQ & ~cbrQ;
  assign casFall    = casPrevN & ~casNowN & inPage;
  assign weFall     = weQ & ~weN & inPage;
  assign refreshHit = rasFall & ~casPrevN;

  always_comb begin
    errNow = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      laneFall[i] = laneQ[i] & ~laneN[i] & inPage;
      earlyW[i]   = laneFall[i] & ~weN;
      rdL[i]      = laneFall[i] & weN;
      lateTry[i]  = weFall & ~laneQ[i] & ~laneN[i] & (modeQ[i] == LM_READ);
      lateW[i]    = lateTry[i] & oeN;
      if ((earlyW[i] && modeQ[i ^ 1] == LM_LATE) || (lateW[i] && modeQ[i ^ 1] == LM_EARLY))
        errNow = 1'b1;
    end
  end

  always_comb begin
    strobe.rowLoad = rasFall & casPrevN;
    strobe.colLoad = casFall;
    strobe.wrEn    = earlyW | lateW;
    strobe.rdLoad  = rdL;
  end

  assign casInt = ~casNowN;
  assign dqOe   = validQ & {LANES{~oeN & ~rasN}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasQ       <= 1'b1;
      weQ        <= 1'b1;
      laneQ      <= '1;
      cbrQ       <= 1'b0;
      validQ     <= '0;
      refCnt     <= '0;
      refreshRow <= '0;
      cycleKind  <= CK_IDLE;
      modeErr    <= 1'b0;
      laneWrite  <= '0;
      for (int i = 0; i < LANES; i++) modeQ[i] <= LM_NONE;
    end else begin
      rasQ      <= rasN;
      weQ       <= weN;
      laneQ     <= laneN;
      laneWrite <= earlyW | lateW;
      modeErr   <= errNow;
      if (refreshHit) begin
        refreshRow <= refCnt;
        refCnt     <= refCnt + 1'b1;
      end
      if (rasRise) cbrQ <= 1'b0;
      else if (refreshHit) cbrQ <= 1'b1;

      if (rasRise)         cycleKind <= CK_IDLE;
      else if (refreshHit) cycleKind <= CK_REFRESH;
      else if (|lateW)     cycleKind <= CK_LATE;
      else if (|earlyW)    cycleKind <= CK_EARLY;
      else if (|rdL)       cycleKind <= CK_READ;

      for (int i = 0; i < LANES; i++) begin
        if (rasRise || casRise) modeQ[i] <= LM_NONE;
        else if (rdL[i])        modeQ[i] <= LM_READ;
        else if (earlyW[i])     modeQ[i] <= LM_EARLY;
        else if (lateW[i])      modeQ[i] <= LM_LATE;

        if (rasRise)                                 validQ[i] <= 1'b0;
        else if (rdL[i])                             validQ[i] <= 1'b1;
        else if (earlyW[i])                          validQ[i] <= 1'b0;
        else if (weFall && !(lateTry[i] && !oeN))    validQ[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/edo_lane_store.sv
module edo_lane_store
  import dram_lane_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int LANE_W   = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dqIn,
  output logic [LANES*LANE_W-1:0] dqOut
);
  localparam int IDX_W = ROW_BITS + COL_BITS;
  localparam int DEPTH = 1 << IDX_W;

  logic [ROW_BITS-1:0] rowQ;
  logic [COL_BITS-1:0] colQ, colUse;
  logic [IDX_W-1:0]    idx;

  assign colUse = strobe.colLoad ? addr[COL_BITS-1:0] : colQ;
  assign idx    = {rowQ, colUse};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ <= '0;
      colQ <= '0;
    end else begin
      if (strobe.rowLoad) rowQ <= addr[ROW_BITS-1:0];
      if (strobe.colLoad) colQ <= addr[COL_BITS-1:0];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] rdData;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int k = 0; k < DEPTH; k++) bank[k] <= '0;
        rdData <= '0;
      end else begin
        if (strobe.wrEn[g])   bank[idx] <= dqIn[g*LANE_W +: LANE_W];
        if (strobe.rdLoad[g]) rdData    <= bank[idx];
      end
    end

    assign dqOut[g*LANE_W +: LANE_W] = rdData;
  end
endmodule

// File: rtl/edo_lane_ctrl.sv
module edo_lane_ctrl
  import dram_lane_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int LANE_W   = 8,
  parameter int REF_W    = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rasN,
  input  logic                    caslN,
  input  logic                    cashN,
  input  logic                    weN,
  input  logic                    oeN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dqIn,
  output logic [LANES*LANE_W-1:0] dqOut,
  output logic [LANES-1:0]        dqOe,
  output logic                    casInt,
  output logic [LANES-1:0]        laneWrite,
  output logic [2:0]              cycleKind,
  output logic [REF_W-1:0]        refreshRow,
  output logic                    modeErr
);
  strobe_t strobe;
  kind_t   kindW;

  edo_lane_seq #(.REF_W(REF_W)) seq_i (
    .clk(clk), .rstN(rstN), .rasN(rasN), .caslN(caslN), .cashN(cashN),
    .weN(weN), .oeN(oeN), .strobe(strobe), .dqOe(dqOe), .casInt(casInt),
    .laneWrite(laneWrite), .cycleKind(kindW), .refreshRow(refreshRow),
    .modeErr(modeErr)
  );

  edo_lane_store #(
    .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .LANE_W(LANE_W)
  ) store_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .dqIn(dqIn), .dqOut(dqOut)
  );

  assign cycleKind = kindW;
endmodule

// File: rtl/edo_lane_ctrl_chk.sv
module edo_lane_ctrl_chk #(
  parameter int REF_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             rasN,
  input logic             caslN,
  input logic             cashN,
  input logic             oeN,
  input logic             casInt,
  input logic [1:0]       dqOe,
  input logic [1:0]       laneWrite,
  input logic [2:0]       cycleKind,
  input logic [REF_W-1:0] refreshRow,
  input logic             modeErr
);
  // R1
  cas_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (caslN && cashN) |-> !casInt);
  // R1
  cas_any_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!caslN || !cashN) |-> casInt);
  // R7
  oe_high_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> (dqOe == 2'b00));
  // R6
  ras_high_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    rasN |-> (dqOe == 2'b00));
  // R9
  refresh_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refreshRow != $past(refreshRow)) |-> (refreshRow == REF_W'($past(refreshRow) + 1'b1)));
  // R9
  refresh_no_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycleKind == 3'd4) |-> (laneWrite == 2'b00));
  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |=> !modeErr);
  // R3
  store_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    (laneWrite != 2'b00) |-> (cycleKind == 3'd2 || cycleKind == 3'd3));
endmodule

bind edo_lane_ctrl edo_lane_ctrl_chk #(.REF_W(REF_W)) chk_i (
  .clk(clk), .rstN(rstN), .rasN(rasN), .caslN(caslN), .cashN(cashN), .oeN(oeN),
  .casInt(casInt), .dqOe(dqOe), .laneWrite(laneWrite), .cycleKind(cycleKind),
  .refreshRow(refreshRow), .modeErr(modeErr)
);

// File: tb/edo_lane_ctrl_tb_top.sv
module edo_lane_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, caslN = 1'b1, cashN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [11:0] addr = '0;
  logic [15:0] dqIn = '0;
  logic [15:0] dqOut;
  logic [1:0]  dqOe, laneWrite;
  logic        casInt, modeErr;
  logic [2:0]  cycleKind;
  logic [11:0] refreshRow;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  edo_lane_ctrl dut_i (
    .clk(clk), .rstN(rstN), .rasN(rasN), .caslN(caslN), .cashN(cashN),
    .weN(weN), .oeN(oeN), .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe),
    .casInt(casInt), .laneWrite(laneWrite), .cycleKind(cycleKind),
    .refreshRow(refreshRow), .modeErr(modeErr)
  );

  // behavioural reference state
  int        pRas = 1, pLane[2] = '{1, 1}, pWe = 1;
  int        mRow = 0, mCol = 0;
  logic [15:0] mArr [16];
  logic [7:0]  mRd [2];
  bit        mVal [2];
  int        mMode [2];
  bit        mCbr = 0;
  int        mCnt = 0;
  int        eRef = 0, eKind = 0;
  bit        eErr = 0;
  logic [1:0] eWr = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    int ln[2];
    int oldMode[2];
    bit casPrevHigh, casNowHigh, page, wFall, anyRd, anyEarly, anyLate;
    int col, idx;
    ln[0] = caslN; ln[1] = cashN;
    oldMode = mMode;
    casPrevHigh = (pLane[0] == 1) && (pLane[1] == 1);
    casNowHigh  = (ln[0] == 1) && (ln[1] == 1);
    page  = (rasN == 0) && (pRas == 0) && !mCbr;
    eErr = 0; eWr = '0; anyRd = 0; anyEarly = 0; anyLate = 0;
    if (pRas == 1 && rasN == 0) begin
      if (!casPrevHigh) begin
        mCbr = 1; eRef = mCnt; mCnt = (mCnt + 1) % 4096; eKind = 4;
      end else mRow = addr % 4;
    end
    if (page) begin
      col = (casPrevHigh && !casNowHigh) ? (addr % 4) : mCol;
      mCol = col;
      idx = mRow * 4 + col;
      wFall = (pWe == 1) && (weN == 0);
      for (int i = 0; i < 2; i++) begin
        bit fell;
        fell = (pLane[i] == 1) && (ln[i] == 0);
        if (fell && weN == 0) begin
          mArr[idx][8*i +: 8] = dqIn[8*i +: 8];
          if (oldMode[1-i] == 3) eErr = 1;
          mMode[i] = 2; mVal[i] = 0; eWr[i] = 1; anyEarly = 1;
        end else if (fell) begin
          mRd[i] = mArr[idx][8*i +: 8];
          mMode[i] = 1; mVal[i] = 1; anyRd = 1;
        end else if (wFall && ln[i] == 0 && oldMode[i] == 1) begin
          if (oeN == 1) begin
            mArr[idx][8*i +: 8] = dqIn[8*i +: 8];
            if (oldMode[1-i] == 2) eErr = 1;
            mMode[i] = 3; mVal[i] = 0; eWr[i] = 1; anyLate = 1;
          end
        end else if (wFall) mVal[i] = 0;
      end
      if (anyLate) eKind = 3;
      else if (anyEarly) eKind = 2;
      else if (anyRd) eKind = 1;
    end
    if (!casPrevHigh && casNowHigh) begin mMode[0] = 0; mMode[1] = 0; end
    if (pRas == 0 && rasN == 1) begin
      mCbr = 0; mVal[0] = 0; mVal[1] = 0; mMode[0] = 0; mMode[1] = 0; eKind = 0;
    end
    pRas = rasN; pLane[0] = ln[0]; pLane[1] = ln[1]; pWe = weN;
  endtask

  task automatic compareAll();
    logic [1:0] eOe;
    for (int i = 0; i < 2; i++) eOe[i] = mVal[i] && !oeN && !rasN;
    chk("R6 model dqOe", dqOe, eOe);
    for (int i = 0; i < 2; i++)
      if (eOe[i]) chk("R6 model dqOut lane", dqOut[8*i +: 8], mRd[i]);
    chk("R1 model casInt", casInt, !(caslN && cashN));
    chk("R10 model cycleKind", cycleKind, eKind);
    chk("R9 model refreshRow", refreshRow, eRef);
    chk("R11 model modeErr", modeErr, eErr);
    chk("R3 model laneWrite", laneWrite, eWr);
  endtask

  task automatic cyc(input logic r, l, h, w, o, input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    rasN = r; caslN = l; cashN = h; weN = w; oeN = o; addr = a; dqIn = d;
    @(posedge clk);
    modelStep();
    #3;
    compareAll();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) mArr[k] = '0;
    mRd[0] = '0; mRd[1] = '0; mVal[0] = 0; mVal[1] = 0; mMode[0] = 0; mMode[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #2;
    // R12 reset state
    chk("R12 dqOe", dqOe, 2'b00);
    chk("R12 cycleKind", cycleKind, 3'd0);
    chk("R12 refreshRow", refreshRow, 12'd0);
    chk("R12 modeErr", modeErr, 1'b0);
    chk("R12 laneWrite", laneWrite, 2'b00);

    // early word write row1 col2
    cyc(0,1,1,1,1,12'd1,16'h0000);
    cyc(0,0,0,0,1,12'd2,16'hA5C3);
    chk("R3 word laneWrite", laneWrite, 2'b11);
    chk("R10 early kind", cycleKind, 3'd2);
    cyc(0,1,1,1,1,12'd2,16'h0000);
    // lower byte early write col3
    cyc(0,0,1,0,1,12'd3,16'hEE11);
    chk("R3 byte laneWrite", laneWrite, 2'b01);
    cyc(0,1,1,1,1,12'd3,16'h0000);
    cyc(0,0,0,1,0,12'd3,16'h0000);
    chk("R3 upper untouched", dqOut, 16'h0011);
    chk("R10 read kind", cycleKind, 3'd1);
    cyc(0,1,1,1,0,12'd0,16'h0000);
    chk("R6 hold after strobe rise oe", dqOe, 2'b11);
    chk("R6 hold after strobe rise data", dqOut, 16'h0011);

    // OE toggling
    cyc(0,0,0,1,0,12'd2,16'h0000);
    chk("R3 word readback", dqOut, 16'hA5C3);
    cyc(0,0,0,1,1,12'd2,16'h0000);
    chk("R7 oe high off", dqOe, 2'b00);
    cyc(0,0,0,1,0,12'd2,16'h0000);
    chk("R7 oe low again", dqOe, 2'b11);
    chk("R7 same data", dqOut, 16'hA5C3);
    chk("R1 both low", casInt, 1'b1);
    cyc(0,1,1,1,0,12'd2,16'h0000);

    // staggered lanes: column from first fall
    cyc(0,0,1,1,0,12'd2,16'h0000);
    chk("R1 lower only", casInt, 1'b1);
    cyc(0,0,0,1,0,12'd3,16'h0000);
    chk("R2 upper uses first column", dqOut[15:8], 8'hA5);
    chk("R2 lower data", dqOut[7:0], 8'hC3);
    cyc(0,1,0,1,0,12'd3,16'h0000);
    chk("R1 upper only", casInt, 1'b1);
    cyc(0,1,1,1,0,12'd3,16'h0000);
    chk("R1 both high", casInt, 1'b0);

    // late write col1
    cyc(0,0,0,1,1,12'd1,16'h0000);
    cyc(0,0,0,0,1,12'd1,16'h1234);
    chk("R4 late laneWrite", laneWrite, 2'b11);
    chk("R10 late kind", cycleKind, 3'd3);
    cyc(0,1,1,0,0,12'd1,16'h0000);
    cyc(0,1,1,1,0,12'd1,16'h0000);
    chk("R8 stays off after we fall", dqOe, 2'b00);
    cyc(0,0,0,1,0,12'd1,16'h0000);
    chk("R8 read restores drive", dqOe, 2'b11);
    chk("R4 late data stored", dqOut, 16'h1234);

    // late write attempt with OE low
    cyc(0,0,0,0,0,12'd1,16'hFFFF);
    chk("R5 no store", laneWrite, 2'b00);
    chk("R5 still driving", dqOe, 2'b11);
    chk("R5 read data kept", dqOut, 16'h1234);
    cyc(0,1,1,1,0,12'd1,16'h0000);
    cyc(0,0,0,1,0,12'd1,16'h0000);
    chk("R5 array unchanged", dqOut, 16'h1234);
    cyc(0,1,1,1,0,12'd1,16'h0000);

    // mixed write modes in one strobe cycle
    cyc(0,0,1,1,1,12'd0,16'h0000);
    cyc(0,0,1,0,1,12'd0,16'h0077);
    chk("R4 lower late", laneWrite, 2'b01);
    cyc(0,0,1,1,1,12'd0,16'h0000);
    cyc(0,0,0,0,1,12'd0,16'h8800);
    chk("R11 err raised", modeErr, 1'b1);
    chk("R3 upper early", laneWrite, 2'b10);
    cyc(0,0,0,0,1,12'd0,16'h0000);
    chk("R11 err one cycle", modeErr, 1'b0);
    cyc(0,1,1,1,1,12'd0,16'h0000);

    cyc(1,1,1,1,0,12'd0,16'h0000);
    chk("R10 idle after ras rise", cycleKind, 3'd0);
    chk("R6 off with ras high", dqOe, 2'b00);

    // refresh cycles and counter wrap
    for (int k = 1; k <= 4097; k++) begin
      cyc(1,0,0,1,1,12'd0,16'h0000);
      cyc(0,0,0,1,1,12'd0,16'h0000);
      if (k == 1) begin
        chk("R9 refresh kind", cycleKind, 3'd4);
        chk("R9 first row", refreshRow, 12'd0);
        cyc(0,1,1,0,1,12'd0,16'hDEAD);
        cyc(0,0,0,0,1,12'd0,16'hDEAD);
        chk("R9 no store in refresh", laneWrite, 2'b00);
      end
      if (k == 4096) chk("R9 last row", refreshRow, 12'd4095);
      if (k == 4097) chk("R9 wrap", refreshRow, 12'd0);
      cyc(1,1,1,1,1,12'd0,16'h0000);
    end
    cyc(0,1,1,1,0,12'd1,16'h0000);
    cyc(0,0,0,1,0,12'd0,16'h0000);
    chk("R9 array intact after refresh", dqOut, 16'h8877);
    cyc(1,1,1,1,1,12'd0,16'h0000);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule